// File: doc/BRIEF.md
# DDR2 Termination Control Sequencer

This block sits beside the command path of a two-slot DDR2 memory controller. It watches each command as it is accepted and produces the per-slot on-die termination (ODT) enables for the DRAM devices. It also produces the controller-side read termination enable for the DQ/DQS pads, together with the strength code that goes with it. During a write, termination is switched on only in the slot that is not being written. The ODT window is placed relative to the write latency so that it covers the whole data burst. It never starts before the write command itself is on the DRAM pins.

A command strobe (`cmd_valid`) in cycle c reaches the DRAM pins in cycle c+1, which is the command launch cycle. Write latency (WL), CAS latency (CL), burst length (BL) and read termination strength are configuration inputs. The block takes a snapshot of them only in cycles when no termination or data window is pending. A window that is already running is therefore never reshaped. Later windows of the same kind merge with earlier ones as a union, so a later window never cuts an earlier one short.

Top module: `ddr2_term_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, all `odt_o` bits, `pad_term_en_o` and `pad_term_sel_o` are 0 from the next cycle on, whatever the command inputs are.
- R2: A write strobed in cycle c to slot s drives `odt_o` high for every other slot in cycles c+1+(WL−2) through c+(WL−2)+BL/2+2, that is for BL/2+2 cycles. The addressed slot's own ODT is not set by that write.
- R3: ODT never rises earlier than cycle c+1, the command launch cycle. With WL of 2, ODT on the non-addressed slot rises exactly in cycle c+1.
- R4: Writes in consecutive cycles to different slots each open their own window on the opposite slot, with that write's own timing.
- R5: A further write that raises the same slot's ODT while its window is pending or active extends that window to the later end. The window is never truncated; the result is the union of both windows.
- R6: `cfg_bl8` = 0 selects BL4 (2 data cycles) and `cfg_bl8` = 1 selects BL8 (4 data cycles). The BL/2 term in every window follows this setting.
- R7: A read strobed in cycle c opens the pad read-termination window for cycles c+1 through c+CL+BL/2. A later read extends the window to its own end.
- R8: `cfg_rtt` gives the pad strength: 2'b01 = 60 ohm, 2'b10 = 120 ohm, and 2'b00 or 2'b11 = off. When the window is open and the code is 01 or 10, `pad_term_en_o` is 1 and `pad_term_sel_o` carries the code. Otherwise both outputs are 0.
- R9: The pads drive write data in cycles c+1+WL through c+WL+BL/2 after a write strobed in cycle c. In those cycles `pad_term_en_o` is 0, even inside an open read window.
- R10: WL, CL, BL and the strength code are sampled only in a cycle when no ODT, read or write-data window is pending. A change made while any window is pending has no effect on outputs until the block is idle again.
- R11: WL values below 2 act as 2, and CL values below 2 act as 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is accepted this cycle |
| cmd_is_wr | input | 1 | 1 = write, 0 = read |
| cmd_slot | input | SLOT_W | Slot addressed by the command |
| cfg_wl | input | 3 | Write latency in clocks |
| cfg_cl | input | 3 | CAS latency in clocks |
| cfg_bl8 | input | 1 | 0 = burst of 4, 1 = burst of 8 |
| cfg_rtt | input | 2 | Pad read termination strength code |
| odt_o | output | NUM_SLOTS | ODT enable per slot |
| pad_term_en_o | output | 1 | Controller pad read termination enable |
| pad_term_sel_o | output | 2 | Pad termination strength, 0 when disabled |

## Verification
All outputs come from registers. A command strobed in cycle c can therefore first show in cycle c+1: ODT appears at c+1+(WL−2), the pad read window at c+1, and the write-drive blanking at c+1+WL. The bench keeps its expected values in per-cycle arrays. When a command is driven, it marks the cycles that command's windows cover, using the configuration snapshot the requirements define. It compares every output at the falling edge of each cycle with the array entry for that cycle, so every latency is checked to the exact cycle, including its first and last cycle.

// File: rtl/ddr2_term_pkg.sv
package ddr2_term_pkg;

    localparam int LAT_W = 3;

    typedef enum logic [1:0] {
        RTT_OFF  = 2'b00,
        RTT_60   = 2'b01,
        RTT_120  = 2'b10,
        RTT_RSVD = 2'b11
    } rtt_code_e;

    typedef struct packed {
        logic [LAT_W-1:0] wl;
        logic [LAT_W-1:0] cl;
        logic             bl8;
        rtt_code_e        rtt;
    } term_cfg_t;

    // Latencies below two behave as two.
    function automatic logic [LAT_W-1:0] lat_floor2(input logic [LAT_W-1:0] v);
        return (v < LAT_W'(2)) ? LAT_W'(2) : v;
    endfunction

    function automatic logic rtt_is_on(input rtt_code_e c);
        return (c == RTT_60) || (c == RTT_120);
    endfunction

endpackage

// File: rtl/ddr2_term_cfg_hold.sv
module ddr2_term_cfg_hold
    import ddr2_term_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      idle,
    input  term_cfg_t cfg_in,
    output term_cfg_t cfg_eff,
    output term_cfg_t cfg_q
);

    typedef struct packed {
        term_cfg_t cfg;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (idle) begin
            st_d.cfg = cfg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg.wl  <= LAT_W'(2);
            st_q.cfg.cl  <= LAT_W'(2);
            st_q.cfg.bl8 <= 1'b0;
            st_q.cfg.rtt <= RTT_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_eff = st_d.cfg;
    assign cfg_q   = st_q.cfg;

endmodule

// File: rtl/ddr2_term_odt_lane.sv
module ddr2_term_odt_lane #(
    parameter int SR_W  = 11,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [LEN_W-1:0] win_off,
    input  logic [LEN_W-1:0] win_len,
    output logic             odt,
    output logic             busy
);

    typedef struct packed {
        logic [SR_W-1:0] sr;
    } lane_st_t;

    lane_st_t        st_d, st_q;
    logic [SR_W-1:0] win_mask;

    always_comb begin
        win_mask = '0;
        for (int j = 0; j < SR_W; j++) begin
            if ((j >= int'(win_off)) && (j < int'(win_off) + int'(win_len))) begin
                win_mask[j] = 1'b1;
            end
        end
        st_d    = st_q;
        st_d.sr = {1'b0, st_q.sr[SR_W-1:1]} | (fire ? win_mask : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign odt  = st_q.sr[0];
    assign busy = |st_q.sr;

endmodule

// File: rtl/ddr2_term_pad_ctl.sv
module ddr2_term_pad_ctl
    import ddr2_term_pkg::*;
#(
    parameter int SR_W  = 11,
    parameter int RD_W  = 4,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_fire,
    input  logic             wr_fire,
    input  logic [RD_W-1:0]  rd_len,
    input  logic [LEN_W-1:0] drv_off,
    input  logic [LEN_W-1:0] drv_len,
    input  rtt_code_e        rtt,
    output logic             term_en,
    output logic [1:0]       term_sel,
    output logic             busy
);

    typedef struct packed {
        logic [RD_W-1:0] rd_cnt;
        logic [SR_W-1:0] drv;
    } pad_st_t;

    pad_st_t         st_d, st_q;
    logic [RD_W-1:0] rd_dec;
    logic [SR_W-1:0] drv_mask;

    always_comb begin
        rd_dec   = (st_q.rd_cnt != '0) ? (st_q.rd_cnt - RD_W'(1)) : '0;
        drv_mask = '0;
        for (int j = 0; j < SR_W; j++) begin
            if ((j >= int'(drv_off)) && (j < int'(drv_off) + int'(drv_len))) begin
                drv_mask[j] = 1'b1;
            end
        end
        st_d        = st_q;
        st_d.rd_cnt = (rd_fire && (rd_len > rd_dec)) ? rd_len : rd_dec;
        st_d.drv    = {1'b0, st_q.drv[SR_W-1:1]} | (wr_fire ? drv_mask : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Read window open, legal strength, and pads not driving write data.
    assign term_en  = (st_q.rd_cnt != '0) && rtt_is_on(rtt) && !st_q.drv[0];
    assign term_sel = term_en ? 2'(rtt) : 2'b00;
    assign busy     = (st_q.rd_cnt != '0) || (|st_q.drv);

endmodule

// File: rtl/ddr2_term_seq.sv
module ddr2_term_seq
    import ddr2_term_pkg::*;
#(
    parameter int NUM_SLOTS = 2,
    parameter int MAX_BLH   = 4,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_is_wr,
    input  logic [SLOT_W-1:0]    cmd_slot,
    input  logic [LAT_W-1:0]     cfg_wl,
    input  logic [LAT_W-1:0]     cfg_cl,
    input  logic                 cfg_bl8,
    input  logic [1:0]           cfg_rtt,
    output logic [NUM_SLOTS-1:0] odt_o,
    output logic                 pad_term_en_o,
    output logic [1:0]           pad_term_sel_o
);

    localparam int MAX_LAT = (1 << LAT_W) - 1;
    localparam int SR_W    = MAX_LAT + MAX_BLH;
    localparam int LEN_W   = $clog2(SR_W + 1);
    localparam int RD_W    = $clog2(MAX_LAT + MAX_BLH + 1);

    term_cfg_t            cfg_live, cfg_eff, cfg_q;
    logic                 cfg_idle;
    logic [NUM_SLOTS-1:0] lane_busy;
    logic                 pad_busy;
    logic                 wr_fire, rd_fire;
    logic [LEN_W-1:0]     blh, odt_off, odt_len;
    logic [RD_W-1:0]      rd_len;

    always_comb begin
        cfg_live.wl  = lat_floor2(cfg_wl);
        cfg_live.cl  = lat_floor2(cfg_cl);
        cfg_live.bl8 = cfg_bl8;
        cfg_live.rtt = rtt_code_e'(cfg_rtt);
    end

    assign cfg_idle = !(|lane_busy) && !pad_busy;
    assign wr_fire  = cmd_valid && cmd_is_wr;
    assign rd_fire  = cmd_valid && !cmd_is_wr;

    ddr2_term_cfg_hold u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .idle    (cfg_idle),
        .cfg_in  (cfg_live),
        .cfg_eff (cfg_eff),
        .cfg_q   (cfg_q)
    );

    assign blh     = cfg_eff.bl8 ? LEN_W'(MAX_BLH) : LEN_W'(MAX_BLH / 2);
    assign odt_off = LEN_W'(cfg_eff.wl) - LEN_W'(2);
    assign odt_len = blh + LEN_W'(2);
    assign rd_len  = RD_W'(cfg_eff.cl) + RD_W'(blh);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_lane
        ddr2_term_odt_lane #(
            .SR_W  (SR_W),
            .LEN_W (LEN_W)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .fire    (wr_fire && (cmd_slot != SLOT_W'(g))),
            .win_off (odt_off),
            .win_len (odt_len),
            .odt     (odt_o[g]),
            .busy    (lane_busy[g])
        );
    end

    ddr2_term_pad_ctl #(
        .SR_W  (SR_W),
        .RD_W  (RD_W),
        .LEN_W (LEN_W)
    ) u_pad (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_fire  (rd_fire),
        .wr_fire  (wr_fire),
        .rd_len   (rd_len),
        .drv_off  (LEN_W'(cfg_eff.wl)),
        .drv_len  (blh),
        .rtt      (cfg_q.rtt),
        .term_en  (pad_term_en_o),
        .term_sel (pad_term_sel_o),
        .busy     (pad_busy)
    );

endmodule

// File: rtl/ddr2_term_seq_chk.sv
module ddr2_term_seq_chk
    import ddr2_term_pkg::*;
#(
    parameter int NUM_SLOTS = 2,
    parameter int SLOT_W    = 1,
    parameter int SR_W      = 11
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic                 cmd_is_wr,
    input logic [SLOT_W-1:0]    cmd_slot,
    input logic [LAT_W-1:0]     cfg_wl,
    input logic                 idle,
    input logic [NUM_SLOTS-1:0] odt_o,
    input logic                 pad_term_en_o,
    input logic [1:0]           pad_term_sel_o
);

    logic [5:0]           wr_age_q, rd_age_q;
    logic [NUM_SLOTS-1:0] slot_mask;

    assign slot_mask = NUM_SLOTS'(1) << cmd_slot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_age_q <= '1;
            rd_age_q <= '1;
        end else begin
            if (cmd_valid && cmd_is_wr)  wr_age_q <= '0;
            else if (wr_age_q != '1)     wr_age_q <= wr_age_q + 6'd1;
            if (cmd_valid && !cmd_is_wr) rd_age_q <= '0;
            else if (rd_age_q != '1)     rd_age_q <= rd_age_q + 6'd1;
        end
    end

    assert_odt_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (odt_o != '0) |-> (int'(wr_age_q) < SR_W));

    assert_wl2_with_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_is_wr && idle && (cfg_wl <= LAT_W'(2)))
        |=> ((odt_o | $past(slot_mask)) == '1));

    assert_rd_term_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pad_term_en_o |-> (int'(rd_age_q) < SR_W));

    assert_sel_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pad_term_en_o |-> ((pad_term_sel_o == 2'b01) || (pad_term_sel_o == 2'b10)));

    assert_sel_zero_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_term_en_o |-> (pad_term_sel_o == 2'b00));

    assert_sel_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_term_en_o && $past(pad_term_en_o)) |-> $stable(pad_term_sel_o));

endmodule

bind ddr2_term_seq ddr2_term_seq_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W),
    .SR_W      (SR_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_is_wr      (cmd_is_wr),
    .cmd_slot       (cmd_slot),
    .cfg_wl         (cfg_wl),
    .idle           (cfg_idle),
    .odt_o          (odt_o),
    .pad_term_en_o  (pad_term_en_o),
    .pad_term_sel_o (pad_term_sel_o)
);

// File: tb/ddr2_term_seq_tb_top.sv
`timescale 1ns/1ps
module ddr2_term_seq_tb_top;

    localparam int NS    = 2;
    localparam int DEPTH = 4096;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmd_valid, cmd_is_wr;
    logic [0:0]    cmd_slot;
    logic [2:0]    cfg_wl, cfg_cl;
    logic          cfg_bl8;
    logic [1:0]    cfg_rtt;
    logic [NS-1:0] odt_o;
    logic          pad_term_en_o;
    logic [1:0]    pad_term_sel_o;

    always #2.5 clk = ~clk;

    ddr2_term_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_wr(cmd_is_wr),
        .cmd_slot(cmd_slot), .cfg_wl(cfg_wl), .cfg_cl(cfg_cl), .cfg_bl8(cfg_bl8),
        .cfg_rtt(cfg_rtt), .odt_o(odt_o), .pad_term_en_o(pad_term_en_o),
        .pad_term_sel_o(pad_term_sel_o)
    );

    bit eodt [NS][DEPTH];
    bit erd  [DEPTH];
    bit edrv [DEPTH];
    int cyc, checks, errors;
    bit done;
    int m_wl, m_cl, m_bl8, m_rtt;
    int c_wl, c_cl, c_bl8, c_rtt;

    function automatic int floor2(input int v);
        return (v < 2) ? 2 : v;
    endfunction

    function automatic bit model_idle(input int c);
        for (int k = c; k < c + 16; k++) begin
            if (erd[k] || edrv[k]) return 1'b0;
            for (int s = 0; s < NS; s++) if (eodt[s][k]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
        end
    endtask

    task automatic step(input bit v, input bit wr, input int slot, input string tag);
        int exp_odt, blh;
        bit exp_en;
        @(negedge clk);
        exp_odt = 0;
        for (int s = 0; s < NS; s++) if (eodt[s][cyc]) exp_odt |= (1 << s);
        exp_en = erd[cyc] && (m_rtt == 1 || m_rtt == 2) && !edrv[cyc];
        check(tag, "odt_o", int'(odt_o), exp_odt);
        check(tag, "pad_term_en_o", int'(pad_term_en_o), int'(exp_en));
        check(tag, "pad_term_sel_o", int'(pad_term_sel_o), exp_en ? m_rtt : 0);
        if (model_idle(cyc)) begin
            m_wl = floor2(c_wl); m_cl = floor2(c_cl); m_bl8 = c_bl8; m_rtt = c_rtt;
        end
        if (v) begin
            blh = m_bl8 ? 4 : 2;
            if (wr) begin
                for (int s = 0; s < NS; s++)
                    if (s != slot)
                        for (int k = cyc + 1 + m_wl - 2; k <= cyc + m_wl + blh; k++) eodt[s][k] = 1'b1;
                for (int k = cyc + 1 + m_wl; k <= cyc + m_wl + blh; k++) edrv[k] = 1'b1;
            end else begin
                for (int k = cyc + 1; k <= cyc + m_cl + blh; k++) erd[k] = 1'b1;
            end
        end
        cmd_valid = v; cmd_is_wr = wr; cmd_slot = 1'(slot);
        cfg_wl = 3'(c_wl); cfg_cl = 3'(c_cl); cfg_bl8 = 1'(c_bl8); cfg_rtt = 2'(c_rtt);
        @(posedge clk);
        cyc++;
    endtask

    task automatic gap(input string tag);
        for (int i = 0; i < 16; i++) step(1'b0, 1'b0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d2e3f40));
        rst_n = 1'b0; cmd_valid = 1'b1; cmd_is_wr = 1'b1; cmd_slot = 1'b0;
        cfg_wl = 3'd2; cfg_cl = 3'd3; cfg_bl8 = 1'b0; cfg_rtt = 2'b01;
        repeat (3) @(posedge clk);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check("R1", "odt_o in reset", int'(odt_o), 0);
            check("R1", "pad_term_en_o in reset", int'(pad_term_en_o), 0);
            check("R1", "pad_term_sel_o in reset", int'(pad_term_sel_o), 0);
            cmd_is_wr = 1'(i);
        end
        // Release with the default configuration; the first free cycle snapshots it.
        c_wl = 5; c_cl = 4; c_bl8 = 0; c_rtt = 1;
        cfg_wl = 3'(c_wl); cfg_cl = 3'(c_cl); cfg_bl8 = 1'(c_bl8); cfg_rtt = 2'(c_rtt);
        cmd_valid = 1'b0; rst_n = 1'b1;
        m_wl = c_wl; m_cl = c_cl; m_bl8 = c_bl8; m_rtt = c_rtt;
        cyc = 0;

        // R2: single write, WL=5, BL4
        step(1, 1, 0, "R2"); gap("R2");
        step(1, 1, 1, "R2"); gap("R2");
        // R3: WL=2, ODT with the command launch
        c_wl = 2; gap("R3");
        step(1, 1, 1, "R3"); gap("R3");
        // R11: WL below 2
        c_wl = 0; gap("R11");
        step(1, 1, 0, "R11"); gap("R11");
        c_wl = 1; c_cl = 0; gap("R11");
        step(1, 0, 0, "R11"); step(1, 1, 1, "R11"); gap("R11");
        // R4: back-to-back writes to different slots
        c_wl = 3; c_cl = 4; gap("R4");
        step(1, 1, 0, "R4"); step(1, 1, 1, "R4"); gap("R4");
        // R5: overlapping writes to the same slot
        c_wl = 4; gap("R5");
        step(1, 1, 1, "R5"); step(0, 0, 0, "R5"); step(1, 1, 1, "R5"); gap("R5");
        step(1, 1, 0, "R5");
        for (int i = 0; i < 5; i++) step(0, 0, 0, "R5");
        step(1, 1, 0, "R5"); gap("R5");
        // R6: BL8
        c_bl8 = 1; c_wl = 3; gap("R6");
        step(1, 1, 0, "R6"); gap("R6");
        step(1, 0, 0, "R6"); gap("R6");
        // R7: reads and extension
        c_bl8 = 0; c_cl = 3; c_rtt = 1; gap("R7");
        step(1, 0, 0, "R7"); step(0, 0, 0, "R7"); step(0, 0, 0, "R7");
        step(1, 0, 1, "R7"); gap("R7");
        // R8: strength codes
        c_rtt = 2; gap("R8"); step(1, 0, 0, "R8"); gap("R8");
        c_rtt = 0; gap("R8"); step(1, 0, 0, "R8"); gap("R8");
        c_rtt = 3; gap("R8"); step(1, 0, 0, "R8"); gap("R8");
        // R9: write data blanks an open read window
        c_rtt = 1; c_cl = 6; c_bl8 = 1; c_wl = 2; gap("R9");
        step(1, 0, 0, "R9"); step(1, 1, 1, "R9"); gap("R9");
        // R10: configuration change while busy
        c_wl = 6; c_bl8 = 0; c_cl = 3; gap("R10");
        step(1, 1, 0, "R10");
        c_wl = 2; c_rtt = 2; c_cl = 7;
        step(1, 1, 1, "R10"); step(1, 0, 0, "R10"); gap("R10");
        step(1, 0, 0, "R10"); gap("R10");

        // Random mix
        for (int i = 0; i < 1500 && cyc < DEPTH - 40; i++) begin
            if ($urandom_range(0, 19) == 0) begin
                c_wl = $urandom_range(0, 7); c_cl = $urandom_range(0, 7);
                c_bl8 = $urandom_range(0, 1); c_rtt = $urandom_range(0, 3);
            end
            step($urandom_range(0, 9) < 3, $urandom_range(0, 1), $urandom_range(0, 1),
                 "R2,R5,R7,R9,R10 random");
        end
        gap("R7");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule